// File: doc/BRIEF.md
# Compare Timer with Prescaler

This block is a memory-mapped timer built around a 32-bit up-counter. A prescaler divides the input clock. Software reads the live count as a continuous time base, programs a compare value some ticks ahead, and receives a level interrupt once the counter reaches that value. A sticky status flag records each match until software clears it by writing a one to the flag bit.

A control bit selects what a match does to the counter. In free-run mode the counter passes through the match undisturbed and wraps naturally at the top of its range. In restart mode the counter returns to zero on the tick after the match, so the block becomes a periodic timer with period compare+1 ticks. The register bus is a plain 32-bit read/write port addressed by byte offset. Read data is combinational and ready is given in the same cycle as the select.

Top module: `cmp_timer`

## Requirements
- R1: After reset every readable register reads 0 and irq is 0.
- R2: The control register (offset 0x00) stores bit 0 (enable), bit 3 (count in wait), bit 6 (clock select) and bit 9 (free-run), and reads 0 in all other bits. The prescaler (offset 0x04) stores and returns only its low 12 bits.
- R3: While enable is 0 the counter (offset 0x24) does not change. Any control write with bit 0 equal to 0 clears the counter to 0.
- R4: With prescaler value N, the counter advances once every N+1 clocks. If enable is written to 1 in cycle w, the counter reads floor((r-w-1)/(N+1)) in cycle r.
- R5: With control bit 9 set, a match leaves the counter counting up past the compare value (offset 0x10) and wrapping from all-ones to 0.
- R6: With control bit 9 clear, the counter goes to 0 on the first tick after it equals the compare value, giving a period of compare+1 ticks.
- R7: Status bit 0 (offset 0x08) becomes 1 in the cycle in which the counter takes the compare value. It then stays 1.
- R8: A status write with bit 0 equal to 1 clears the flag. A status write with bit 0 equal to 0 leaves it unchanged.
- R9: If a flag clear and a new match fall in the same cycle, the flag stays 1.
- R10: irq is the AND of the flag and interrupt-enable bit 0 (offset 0x0C). Clearing the enable does not clear a pending flag.
- R11: Reads of unmapped or unaligned offsets return 0. Writes to the counter offset or to unmapped offsets change no register.
- R12: bus_ready is high in exactly the cycles in which bus_sel is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| bus_ready | output | 1 | Access accepted this cycle |
| irq | output | 1 | Level interrupt: flag AND enable |

## Verification
The bench predicts every counter read from the cycle of the enabling write. An off-by-one in the prescaler divider, or a counter that starts a cycle late, therefore shows up as a wrong count. In restart mode it reads across the wrap at the compare value. A design that restarted on the match itself, rather than on the tick after it, would give a period one short. It aims a flag clear at the exact cycle of a new match, so a design that let the clear win would lose the event. It also drops the interrupt enable while a flag is pending; a design that cleared the flag as a side effect would read 0 afterwards.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  // register byte offsets
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_PRESC = 'h04;
  localparam int OFF_STAT  = 'h08;
  localparam int OFF_IEN   = 'h0C;
  localparam int OFF_CMP   = 'h10;
  localparam int OFF_CNT   = 'h24;

  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_WAIT  = 3;
  localparam int CB_CLK   = 6;
  localparam int CB_FREE  = 9;

  typedef struct packed {
    logic free_run;
    logic clk_sel;
    logic wait_en;
    logic en;
  } ctrl_t;

  // place stored control fields back into their bit positions
  function automatic logic [31:0] ctrl_word(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[CB_EN]   = c.en;
    w[CB_WAIT] = c.wait_en;
    w[CB_CLK]  = c.clk_sel;
    w[CB_FREE] = c.free_run;
    return w;
  endfunction

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int PRESC_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_ready,
  input  logic [DATA_W-1:0]  cnt_val,
  input  logic               flag,
  output logic               run_en,
  output logic               free_run,
  output logic [PRESC_W-1:0] presc,
  output logic [DATA_W-1:0]  cmp_val,
  output logic               irq_en,
  output logic               cnt_clr,
  output logic               flag_clr
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFF_PRESC);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] A_CMP   = ADDR_W'(OFF_CMP);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFF_CNT);

  ctrl_t ctrl_q;
  logic  wr;
  logic  wr_ctrl, wr_presc, wr_stat, wr_ien, wr_cmp;

  assign wr       = bus_sel && bus_we;
  assign wr_ctrl  = wr && (bus_addr == A_CTRL);
  assign wr_presc = wr && (bus_addr == A_PRESC);
  assign wr_stat  = wr && (bus_addr == A_STAT);
  assign wr_ien   = wr && (bus_addr == A_IEN);
  assign wr_cmp   = wr && (bus_addr == A_CMP);

  // named events for the counter core
  assign cnt_clr  = wr_ctrl && !bus_wdata[CB_EN];
  assign flag_clr = wr_stat && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc   <= '0;
      cmp_val <= '0;
      irq_en  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en       <= bus_wdata[CB_EN];
        ctrl_q.wait_en  <= bus_wdata[CB_WAIT];
        ctrl_q.clk_sel  <= bus_wdata[CB_CLK];
        ctrl_q.free_run <= bus_wdata[CB_FREE];
      end
      if (wr_presc) presc   <= bus_wdata[PRESC_W-1:0];
      if (wr_cmp)   cmp_val <= bus_wdata;
      if (wr_ien)   irq_en  <= bus_wdata[0];
    end
  end

  assign run_en   = ctrl_q.en;
  assign free_run = ctrl_q.free_run;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = DATA_W'(ctrl_word(ctrl_q));
        A_PRESC: bus_rdata = DATA_W'(presc);
        A_STAT:  bus_rdata = DATA_W'(flag);
        A_IEN:   bus_rdata = DATA_W'(irq_en);
        A_CMP:   bus_rdata = cmp_val;
        A_CNT:   bus_rdata = cnt_val;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign bus_ready = bus_sel;

  // R11: a write to the counter offset raises no register event
  assert_cnt_readonly_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_CNT) |=> ($stable(cmp_val) && $stable(presc) && $stable(irq_en)));

  // R2: control readback never shows bits outside the stored set
  assert_ctrl_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == A_CTRL) |->
      ((bus_rdata & ~(DATA_W'(1) << CB_EN | DATA_W'(1) << CB_WAIT |
                      DATA_W'(1) << CB_CLK | DATA_W'(1) << CB_FREE)) == '0));

endmodule

// File: rtl/cmp_timer_presc.sv
module cmp_timer_presc #(
  parameter int PRESC_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);

  logic [PRESC_W-1:0] div_q;

  // a lowered prescaler still ends the current period at once
  function automatic logic period_done(input logic [PRESC_W-1:0] d,
                                       input logic [PRESC_W-1:0] lim);
    return d >= lim;
  endfunction

  assign tick = run_en && period_done(div_q, presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (!run_en) div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  // R4: the divider is parked at zero whenever the timer is off
  assert_div_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (div_q == '0));

  // R3: no tick reaches the counter while disabled
  assert_no_tick_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !tick);

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              free_run,
  input  logic [DATA_W-1:0] cmp_val,
  input  logic              cnt_clr,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] cnt_q,
  output logic              flag_q,
  output logic              match_evt
);

  logic [DATA_W-1:0] cnt_nxt;

  // next count on a tick: restart after a match unless free-running
  function automatic logic [DATA_W-1:0] next_count(input logic [DATA_W-1:0] c,
                                                   input logic [DATA_W-1:0] m,
                                                   input logic fr);
    if (!fr && c == m) return '0;
    return c + 1'b1;
  endfunction

  assign cnt_nxt   = next_count(cnt_q, cmp_val, free_run);
  assign match_evt = tick && !cnt_clr && (cnt_nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (match_evt) flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_clr) |=> $stable(cnt_q));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == '0));

  assert_free_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && free_run && !cnt_clr) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !free_run && !cnt_clr && cnt_q == cmp_val) |=> (cnt_q == '0));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (flag_q && cnt_q == cmp_val));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match_evt) |=> !flag_q);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && match_evt) |=> flag_q);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int PRESC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              irq
);

  logic               run_en, free_run, irq_en;
  logic               cnt_clr, flag_clr, tick, match_evt, flag;
  logic [PRESC_W-1:0] presc;
  logic [DATA_W-1:0]  cmp_val, cnt_val;

  cmp_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .cnt_val(cnt_val), .flag(flag),
    .run_en(run_en), .free_run(free_run), .presc(presc),
    .cmp_val(cmp_val), .irq_en(irq_en),
    .cnt_clr(cnt_clr), .flag_clr(flag_clr)
  );

  cmp_timer_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .presc(presc), .tick(tick)
  );

  cmp_timer_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .free_run(free_run),
    .cmp_val(cmp_val), .cnt_clr(cnt_clr), .flag_clr(flag_clr),
    .cnt_q(cnt_val), .flag_q(flag), .match_evt(match_evt)
  );

  assign irq = flag && irq_en;

  // R10: a pending match stays asserted on irq while enabled
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && irq_en) |=> irq);

  // R12: every access completes in its own cycle
  assert_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> bus_sel);

endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int en_cyc = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares each read against the scoreboard and checks ready
  always @(negedge clk) begin
    if (rst_n && bus_sel) begin
      checks++;
      if (bus_ready !== 1'b1) begin
        errors++;
        $display("FAIL R12 ready actual=%b expected=1", bus_ready);
      end
      if (!bus_we) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s addr=%h actual=%h expected=%h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 8'h00 && d[0]) en_cyc = cyc;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
  endtask

  // counter read predicted from the cycle of the enabling write
  task automatic rd_cnt(input int n, input int modulo, input string t);
    int k;
    logic [31:0] e;
    @(posedge clk); #1;
    k = cyc - en_cyc - 1;
    e = 32'(k / (n + 1));
    if (modulo > 0) e = e % 32'(modulo);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'h24;
  endtask

  task automatic chk_irq(input logic e, input string t);
    idle();
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h04, 32'h0, "R1 presc");
    rd(8'h08, 32'h0, "R1 stat");
    rd(8'h0C, 32'h0, "R1 ien");
    rd(8'h10, 32'h0, "R1 cmp");
    rd(8'h24, 32'h0, "R1 cnt");

    // R2 control and prescaler field storage
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_0249, "R2 ctrl all ones");
    wr(8'h00, 32'h0000_0248);
    rd(8'h00, 32'h0000_0248, "R2 ctrl no enable");
    rd(8'h24, 32'h0, "R3 cleared by ctrl write");
    idle(); idle(); idle();
    rd(8'h24, 32'h0, "R3 no advance while off");
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0000_0FFF, "R2 presc width");

    // R4 / R5 free run, prescaler 0
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0000_0201);
    for (int i = 0; i < 4; i++) rd_cnt(0, 0, "R4 presc0 count");
    idle(); idle();
    rd_cnt(0, 0, "R4 presc0 later");

    // R4 prescaler 3
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h3);
    wr(8'h00, 32'h0000_0201);
    for (int i = 0; i < 10; i++) rd_cnt(3, 0, "R4 presc3 count");

    // R6 / R7 restart mode, compare 5
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h1);
    wr(8'h10, 32'h5);
    rd(8'h08, 32'h0, "R8 flag cleared before run");
    wr(8'h00, 32'h0000_0001);
    for (int i = 0; i < 9; i++) rd_cnt(0, 6, "R6 restart period");
    rd(8'h08, 32'h1, "R7 flag set on match");

    // R10 interrupt gating
    chk_irq(1'b0, "R10 masked");
    wr(8'h0C, 32'h1);
    chk_irq(1'b1, "R10 enabled");
    wr(8'h0C, 32'h0);
    chk_irq(1'b0, "R10 disabled");
    rd(8'h08, 32'h1, "R10 flag kept pending");

    // R8 write-one-to-clear
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h1, "R8 write zero ignored");
    wr(8'h08, 32'h1);
    rd(8'h08, 32'h0, "R8 write one clears");

    // R9 set wins over clear; R5 counter runs past compare
    wr(8'h10, 32'h4);
    wr(8'h00, 32'h0000_0201);
    idle(); idle(); idle();
    wr(8'h08, 32'h1);
    rd(8'h08, 32'h1, "R9 set beats clear");
    rd_cnt(0, 0, "R5 past compare");
    rd_cnt(0, 0, "R5 past compare next");

    // R11 unmapped and read-only offsets
    wr(8'h00, 32'h0);
    wr(8'h24, 32'h0000_1234);
    rd(8'h24, 32'h0, "R11 counter write ignored");
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, 32'h0, "R11 unmapped read");
    rd(8'h18, 32'h0, "R11 gap read");
    rd(8'h02, 32'h0, "R11 unaligned read");
    rd(8'h10, 32'h4, "R11 cmp unchanged");
    rd(8'h04, 32'h0, "R11 presc unchanged");
    idle();
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule